// File: doc/BRIEF.md
# Exclusive-Aware AHB-Lite to AXI3 Bridge

The bridge sits between the data port of a small microcontroller core and an AXI3 fabric. It takes single AHB-Lite transfers and turns each into one single-beat AXI3 read or write. It also carries the core's exclusive-access sideband across the boundary, where a plain bridge would drop it. An exclusive-request bit that arrives with the AHB address phase becomes the lock attribute on the matching AXI address channel. The AXI response to that transaction then decides an exclusive-fail output, which the core samples when its data phase ends. A separate clear-exclusive strobe from the core leaves the bridge as a one-cycle pulse for the downstream exclusive monitor.

Only one transfer is in flight at a time. The bridge holds `hreadyout` low from the edge that accepts an address phase until the AXI response has been taken. It then ends the data phase with either an OKAY completion or the two-cycle AHB ERROR response.

All five AXI channels follow valid/ready rules, and the bridge honours back-pressure on each of them:
- Once `awvalid`, `wvalid` or `arvalid` is raised, it stays high, with its payload and lock stable, until the fabric accepts it. The write address and the write data are tracked independently, so they may be accepted in either order.
- `bready` is high only while a write response is awaited, and `rready` only while read data is awaited.
- The write data comes straight from `hwdata`. The AHB master keeps `hwdata` stable for the whole stalled data phase.

Top module: `ahb_axi_excl_bridge`

## Requirements
- R1: On an accepted read, `arlock` is 2'b01 when `hexcl` was high in the address phase and 2'b00 otherwise. While `arvalid` is low, `arlock` is 2'b00. The encoding 2'b10 is never produced.
- R2: On an accepted write, `awlock` is 2'b01 when `hexcl` was high and 2'b00 otherwise. `awaddr` equals the captured `haddr`. While `awvalid` is low, `awlock` is 2'b00.
- R3: For an exclusive write, `hex_fail` is low in the final data-phase cycle (the one with `hreadyout` high) when `bresp` was 2'b01. For any other `bresp` it is high in that cycle.
- R4: For an exclusive read, `hex_fail` is low in the final cycle when `rresp` was 2'b01 and high when `rresp` was 2'b00. In both cases `hrdata` carries `rdata` in that cycle.
- R5: For a transfer without the exclusive request, `hex_fail` is low in the final cycle. `hex_fail` is also low whenever `hreadyout` is low.
- R6: `hreadyout` is low from the accepting edge until the edge after the response handshake. With the fabric accepting the address in the first cycle and answering D cycles later, an OKAY-class transfer has exactly D+2 wait cycles. An AXI request stays valid and stable until it is accepted, and no second request starts while one is pending.
- R7: An AXI response of 2'b10 or 2'b11 on R or B gives the two-cycle AHB ERROR: one cycle with `hresp`=1 and `hreadyout`=0, then one with `hresp`=1 and `hreadyout`=1. An exclusive transfer reports `hex_fail` high in the second of these cycles.
- R8: A rising level on `clr_excl_in` produces `clr_excl_out` high in exactly the one cycle after the edge that first samples it high, however long the input stays high.
- R9: `wstrb` enables byte lane i (bits 8i+7:8i, little-endian) exactly when lane i lies in the naturally aligned 2^`hsize`-byte field addressed by the low `haddr` bits. `wdata` equals `hwdata`.
- R10: An address phase with `hsel` low, with `htrans` IDLE (2'b00) or BUSY (2'b01), or with `hready` low starts no AXI request and leaves `hreadyout` high.
- R11: After reset, `hreadyout` is 1, and `hresp`, `hex_fail`, `clr_excl_out`, `awvalid`, `wvalid` and `arvalid` are 0.
- R12: A new address phase presented in the final cycle of a previous transfer, including the second ERROR cycle, is accepted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsel | input | 1 | Bridge selected |
| htrans | input | 2 | AHB transfer type (NONSEQ/SEQ start a transfer) |
| hwrite | input | 1 | 1 = write |
| haddr | input | AW | Byte address |
| hsize | input | 3 | log2 of transfer bytes |
| hwdata | input | DW | Write data, held through the data phase |
| hready | input | 1 | Bus-wide ready |
| hexcl | input | 1 | Exclusive request, address phase |
| hrdata | output | DW | Read data |
| hreadyout | output | 1 | Data phase done |
| hresp | output | 1 | 1 = ERROR |
| hex_fail | output | 1 | Exclusive failed, valid in the final data-phase cycle |
| clr_excl_in | input | 1 | Clear-exclusive strobe from the core |
| clr_excl_out | output | 1 | One-cycle clear pulse to the monitor |
| awvalid | output | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| awaddr | output | AW | Write address |
| awsize | output | 3 | Write beat size |
| awlock | output | 2 | Write lock: 00 normal, 01 exclusive |
| wvalid | output | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| wdata | output | DW | Write data |
| wstrb | output | DW/8 | Byte enables |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Write response ready |
| bresp | input | 2 | Write response |
| arvalid | output | 1 | Read address valid |
| arready | input | 1 | Read address ready |
| araddr | output | AW | Read address |
| arsize | output | 3 | Read beat size |
| arlock | output | 2 | Read lock: 00 normal, 01 exclusive |
| rvalid | input | 1 | Read data valid |
| rready | output | 1 | Read data ready |
| rdata | input | DW | Read data |
| rresp | input | 2 | Read response |

## Verification
The bench separates plain OKAY from EXOKAY on both the read and the write path. A bridge that treats either as plain success, or that swaps the meaning of the fail bit, reports a failed store-exclusive as a success. It counts wait cycles exactly, with and without extra fabric latency, and with error responses. A design that released `hreadyout` one edge early or late, or that shortened the ERROR pair, would show the wrong count or the wrong `hresp` sequence. Sub-word writes at non-zero offsets catch a wrong strobe shift. Clear-exclusive strobes that are held high several cycles would expose a level passed through instead of a single pulse. Idle, BUSY, deselected and not-ready address phases, and transfers chained directly onto a completion or an error, catch a wrong acceptance condition.

// File: rtl/ahb_axi_excl_pkg.sv
package ahb_axi_excl_pkg;
  typedef enum logic [2:0] {
    BR_IDLE, BR_WADDR, BR_WRESP, BR_RADDR, BR_RDATA, BR_DONE, BR_ERR1, BR_ERR2
  } br_state_e;

  localparam logic [1:0] LOCK_NORMAL = 2'b00;
  localparam logic [1:0] LOCK_EXCL   = 2'b01;
  localparam logic [1:0] RSP_EXOKAY  = 2'b01;
  localparam logic [1:0] HTR_NONSEQ  = 2'b10;
  localparam logic [1:0] HTR_SEQ     = 2'b11;
endpackage

// File: rtl/axi_resp_classify.sv
module axi_resp_classify
  import ahb_axi_excl_pkg::*;
(
  input  logic [1:0] resp,
  input  logic       excl,
  output logic       is_err,
  output logic       ex_fail
);
  // SLVERR and DECERR both have the upper bit set
  assign is_err  = resp[1];
  // an exclusive access succeeds only on EXOKAY
  assign ex_fail = excl && (resp != RSP_EXOKAY);
endmodule

// File: rtl/excl_clear_pulse.sv
module excl_clear_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic pulse
);
  logic prev_q, pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      prev_q  <= req;
      pulse_q <= req && !prev_q;
    end
  end

  assign pulse = pulse_q;
endmodule

// File: rtl/ahb_lane_strobe.sv
module ahb_lane_strobe #(
  parameter int NB = 4
) (
  input  logic [$clog2(NB)-1:0] offset,
  input  logic [2:0]            size,
  output logic [NB-1:0]         strb
);
  localparam int OW = $clog2(NB);

  // lane i is enabled when it shares the aligned 2^size field with offset
  for (genvar i = 0; i < NB; i++) begin : g_lane
    localparam logic [OW-1:0] LANE = OW'(i);
    assign strb[i] = ((LANE >> size) == (offset >> size));
  end
endmodule

// File: rtl/ahb_axi_excl_bridge.sv
module ahb_axi_excl_bridge
  import ahb_axi_excl_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsel,
  input  logic [1:0]        htrans,
  input  logic              hwrite,
  input  logic [AW-1:0]     haddr,
  input  logic [2:0]        hsize,
  input  logic [DW-1:0]     hwdata,
  input  logic              hready,
  input  logic              hexcl,
  output logic [DW-1:0]     hrdata,
  output logic              hreadyout,
  output logic              hresp,
  output logic              hex_fail,
  input  logic              clr_excl_in,
  output logic              clr_excl_out,
  output logic              awvalid,
  input  logic              awready,
  output logic [AW-1:0]     awaddr,
  output logic [2:0]        awsize,
  output logic [1:0]        awlock,
  output logic              wvalid,
  input  logic              wready,
  output logic [DW-1:0]     wdata,
  output logic [DW/8-1:0]   wstrb,
  input  logic              bvalid,
  output logic              bready,
  input  logic [1:0]        bresp,
  output logic              arvalid,
  input  logic              arready,
  output logic [AW-1:0]     araddr,
  output logic [2:0]        arsize,
  output logic [1:0]        arlock,
  input  logic              rvalid,
  output logic              rready,
  input  logic [DW-1:0]     rdata,
  input  logic [1:0]        rresp
);
  localparam int NB = DW / 8;
  localparam int OW = $clog2(NB);

  br_state_e       st_q, st_d;
  logic [AW-1:0]   addr_q;
  logic [2:0]      size_q;
  logic            excl_q, aw_done_q, w_done_q, fail_q;
  logic [DW-1:0]   rdata_q;
  logic            can_accept, accept;
  logic            wr_err, wr_fail, rd_err, rd_fail;

  assign can_accept = (st_q == BR_IDLE) || (st_q == BR_DONE) || (st_q == BR_ERR2);
  assign accept = can_accept && hsel && hready &&
                  ((htrans == HTR_NONSEQ) || (htrans == HTR_SEQ));

  axi_resp_classify u_wr_cls (.resp(bresp), .excl(excl_q), .is_err(wr_err), .ex_fail(wr_fail));
  axi_resp_classify u_rd_cls (.resp(rresp), .excl(excl_q), .is_err(rd_err), .ex_fail(rd_fail));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      BR_IDLE, BR_DONE, BR_ERR2:
        st_d = accept ? (hwrite ? BR_WADDR : BR_RADDR) : BR_IDLE;
      BR_WADDR:
        if ((aw_done_q || awready) && (w_done_q || wready)) st_d = BR_WRESP;
      BR_WRESP:
        if (bvalid) st_d = wr_err ? BR_ERR1 : BR_DONE;
      BR_RADDR:
        if (arready) st_d = BR_RDATA;
      BR_RDATA:
        if (rvalid) st_d = rd_err ? BR_ERR1 : BR_DONE;
      BR_ERR1:
        st_d = BR_ERR2;
      default:
        st_d = BR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= BR_IDLE;
      addr_q    <= '0;
      size_q    <= '0;
      excl_q    <= 1'b0;
      aw_done_q <= 1'b0;
      w_done_q  <= 1'b0;
      fail_q    <= 1'b0;
      rdata_q   <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        addr_q    <= haddr;
        size_q    <= hsize;
        excl_q    <= hexcl;
        aw_done_q <= 1'b0;
        w_done_q  <= 1'b0;
      end else begin
        if (awvalid && awready) aw_done_q <= 1'b1;
        if (wvalid && wready)   w_done_q  <= 1'b1;
      end
      if (bvalid && bready) fail_q <= wr_fail;
      if (rvalid && rready) begin
        fail_q  <= rd_fail;
        rdata_q <= rdata;
      end
    end
  end

  // write channels
  assign awvalid = (st_q == BR_WADDR) && !aw_done_q;
  assign wvalid  = (st_q == BR_WADDR) && !w_done_q;
  assign awaddr  = addr_q;
  assign awsize  = size_q;
  assign awlock  = (awvalid && excl_q) ? LOCK_EXCL : LOCK_NORMAL;
  assign wdata   = hwdata;
  assign bready  = (st_q == BR_WRESP);

  ahb_lane_strobe #(.NB(NB)) u_strb (
    .offset (addr_q[OW-1:0]),
    .size   (size_q),
    .strb   (wstrb)
  );

  // read channels
  assign arvalid = (st_q == BR_RADDR);
  assign araddr  = addr_q;
  assign arsize  = size_q;
  assign arlock  = (arvalid && excl_q) ? LOCK_EXCL : LOCK_NORMAL;
  assign rready  = (st_q == BR_RDATA);

  // AHB data phase
  assign hreadyout = can_accept;
  assign hresp     = (st_q == BR_ERR1) || (st_q == BR_ERR2);
  assign hex_fail  = ((st_q == BR_DONE) || (st_q == BR_ERR2)) && fail_q;
  assign hrdata    = rdata_q;

  excl_clear_pulse u_clr (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (clr_excl_in),
    .pulse (clr_excl_out)
  );
endmodule

// File: rtl/ahb_axi_excl_bridge_chk.sv
module ahb_axi_excl_bridge_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hreadyout,
  input logic          hresp,
  input logic          hex_fail,
  input logic          clr_excl_out,
  input logic          awvalid,
  input logic          awready,
  input logic [AW-1:0] awaddr,
  input logic [1:0]    awlock,
  input logic          arvalid,
  input logic          arready,
  input logic [AW-1:0] araddr,
  input logic [1:0]    arlock
);
  assert_arlock_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !arvalid |-> arlock == 2'b00);
  assert_arlock_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    arvalid |-> !arlock[1]);
  assert_awlock_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !awvalid |-> awlock == 2'b00);
  assert_fail_in_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !hreadyout |-> !hex_fail);
  assert_aw_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (awvalid && !awready) |=> (awvalid && $stable(awaddr) && $stable(awlock)));
  assert_ar_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (arvalid && !arready) |=> (arvalid && $stable(araddr) && $stable(arlock)));
  assert_one_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (awvalid || arvalid) |-> (!hreadyout && !(awvalid && arvalid)));
  assert_err_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hresp && !hreadyout) |=> (hresp && hreadyout));
  assert_err_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hresp) |-> !hreadyout);
  assert_clr_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_excl_out |=> !clr_excl_out);
endmodule

bind ahb_axi_excl_bridge ahb_axi_excl_bridge_chk #(.AW(AW)) u_chk (.*);

// File: tb/tb_ahb_axi_excl_bridge.sv
`timescale 1ns/1ps
module tb_ahb_axi_excl_bridge;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsel = 0, hwrite = 0, hexcl = 0, hready_mask = 1'b1, clr_excl_in = 0;
  logic [1:0] htrans = 0;
  logic [31:0] haddr = 0, hwdata = 0;
  logic [2:0] hsize = 0;
  logic hready;
  logic [31:0] hrdata;
  logic hreadyout, hresp, hex_fail, clr_excl_out;
  logic awvalid, awready = 0, wvalid, wready = 0, bvalid = 0, bready;
  logic arvalid, arready = 0, rvalid = 0, rready;
  logic [31:0] awaddr, wdata, araddr, rdata = 0;
  logic [2:0] awsize, arsize;
  logic [1:0] awlock, arlock, bresp = 0, rresp = 0;
  logic [3:0] wstrb;

  int n_tests = 0, n_fail = 0;
  logic finished = 1'b0;
  logic [31:0] got_addr, got_wdata;
  logic [1:0] got_lock;
  logic [3:0] got_strb;

  assign hready = hreadyout && hready_mask;

  always #4 clk = ~clk;

  ahb_axi_excl_bridge dut (.*);

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drives one AHB transfer; called at a negedge with hreadyout high
  task automatic ahb_xfer(input logic wr, input logic [31:0] addr, input logic [2:0] size,
                          input logic excl, input logic [31:0] wd,
                          output int lows, output logic err_first, output logic err_last,
                          output logic xf, output logic [31:0] rd);
    hsel = 1; htrans = 2'b10; hwrite = wr; haddr = addr; hsize = size; hexcl = excl;
    @(posedge clk);
    @(negedge clk);
    hsel = 0; htrans = 2'b00; hwrite = 0; hexcl = 0; hwdata = wd;
    lows = 0; err_first = 0;
    while (!hreadyout) begin
      lows++;
      err_first = hresp;
      if (hex_fail) chk("R5", "hex_fail during wait", 32'(hex_fail), 32'd0);
      @(negedge clk);
    end
    err_last = hresp; xf = hex_fail; rd = hrdata;
  endtask

  task automatic slv_write(input int d, input logic [1:0] resp);
    do @(negedge clk); while (!(awvalid && wvalid));
    awready = 1; wready = 1; got_addr = awaddr; got_lock = awlock; got_strb = wstrb;
    @(negedge clk);
    got_wdata = wdata; awready = 0; wready = 0;
    repeat (d) @(negedge clk);
    bvalid = 1; bresp = resp;
    @(negedge clk);
    bvalid = 0; bresp = 0;
  endtask

  task automatic slv_read(input int d, input logic [1:0] resp, input logic [31:0] data);
    do @(negedge clk); while (!arvalid);
    arready = 1; got_addr = araddr; got_lock = arlock;
    @(negedge clk);
    arready = 0;
    repeat (d) @(negedge clk);
    rvalid = 1; rresp = resp; rdata = data;
    @(negedge clk);
    rvalid = 0; rresp = 0; rdata = 0;
  endtask

  task automatic run_write(input string tag, input logic excl, input logic [1:0] resp, input int d,
                           input logic [31:0] addr, input logic [2:0] size, input logic [31:0] wd,
                           input logic [3:0] exp_strb, input logic exp_fail);
    int lows; logic ef, el, xf; logic [31:0] rd;
    logic is_err;
    is_err = resp[1];
    fork
      ahb_xfer(1'b1, addr, size, excl, wd, lows, ef, el, xf, rd);
      slv_write(d, resp);
    join
    chk("R2", "awlock", 32'(got_lock), excl ? 32'd1 : 32'd0);
    chk("R2", "awaddr", got_addr, addr);
    chk("R9", "wstrb", 32'(got_strb), 32'(exp_strb));
    chk("R9", "wdata", got_wdata, wd);
    chk("R6", "wait cycles", 32'(lows), is_err ? 32'(d + 3) : 32'(d + 2));
    chk("R7", "final hresp", 32'(el), 32'(is_err));
    if (is_err) chk("R7", "first error cycle hresp", 32'(ef), 32'd1);
    chk(tag, "hex_fail", 32'(xf), 32'(exp_fail));
  endtask

  task automatic run_read(input string tag, input logic excl, input logic [1:0] resp, input int d,
                          input logic [31:0] addr, input logic [31:0] data, input logic exp_fail);
    int lows; logic ef, el, xf; logic [31:0] rd;
    logic is_err;
    is_err = resp[1];
    fork
      ahb_xfer(1'b0, addr, 3'd2, excl, 32'd0, lows, ef, el, xf, rd);
      slv_read(d, resp, data);
    join
    chk("R1", "arlock", 32'(got_lock), excl ? 32'd1 : 32'd0);
    chk("R1", "araddr", got_addr, addr);
    chk("R6", "wait cycles", 32'(lows), is_err ? 32'(d + 3) : 32'(d + 2));
    chk("R7", "final hresp", 32'(el), 32'(is_err));
    if (is_err) chk("R7", "first error cycle hresp", 32'(ef), 32'd1);
    else chk("R4", "hrdata", rd, data);
    chk(tag, "hex_fail", 32'(xf), 32'(exp_fail));
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R11", "hreadyout", 32'(hreadyout), 32'd1);
    chk("R11", "hresp", 32'(hresp), 32'd0);
    chk("R11", "hex_fail", 32'(hex_fail), 32'd0);
    chk("R11", "clr_excl_out", 32'(clr_excl_out), 32'd0);
    chk("R11", "requests", 32'({awvalid, wvalid, arvalid}), 32'd0);
  endtask

  task automatic t_ignored;
    // R10: idle, busy, deselected and not-ready phases start nothing
    for (int k = 0; k < 4; k++) begin
      hsel = (k != 2); hwrite = k[0]; haddr = 32'h40;
      htrans = (k == 0) ? 2'b00 : (k == 1) ? 2'b01 : 2'b10;
      hready_mask = (k != 3);
      repeat (2) @(negedge clk);
      chk("R10", "requests", 32'({awvalid, wvalid, arvalid}), 32'd0);
      chk("R10", "hreadyout", 32'(hreadyout), 32'd1);
    end
    hsel = 0; htrans = 0; hwrite = 0; hready_mask = 1;
    @(negedge clk);
  endtask

  task automatic t_clear;
    int highs;
    // R8: held strobe gives one pulse, one cycle after the edge
    clr_excl_in = 1;
    @(negedge clk);
    chk("R8", "pulse after rise", 32'(clr_excl_out), 32'd1);
    highs = 1;
    repeat (3) begin
      @(negedge clk);
      if (clr_excl_out) highs++;
    end
    clr_excl_in = 0;
    repeat (2) begin
      @(negedge clk);
      if (clr_excl_out) highs++;
    end
    chk("R8", "pulse count held input", 32'(highs), 32'd1);
    clr_excl_in = 1;
    @(negedge clk);
    clr_excl_in = 0;
    chk("R8", "second pulse", 32'(clr_excl_out), 32'd1);
    @(negedge clk);
    chk("R8", "second pulse ends", 32'(clr_excl_out), 32'd0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL R6 watchdog: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ignored();
    // plain and exclusive writes (R2, R3, R5, R9)
    run_write("R5", 1'b0, 2'b00, 0, 32'h1000, 3'd2, 32'hDEADBEEF, 4'hF, 1'b0);
    run_write("R3", 1'b1, 2'b01, 0, 32'h1004, 3'd2, 32'h12345678, 4'hF, 1'b0);
    run_write("R3", 1'b1, 2'b00, 2, 32'h1008, 3'd2, 32'hCAFEF00D, 4'hF, 1'b1);
    run_write("R9", 1'b0, 2'b00, 1, 32'h2002, 3'd0, 32'h00AA0000, 4'b0100, 1'b0);
    run_write("R9", 1'b0, 2'b00, 0, 32'h2002, 3'd1, 32'hBBBB0000, 4'b1100, 1'b0);
    run_write("R9", 1'b1, 2'b01, 0, 32'h2003, 3'd0, 32'h11000000, 4'b1000, 1'b0);
    // errors (R7), then an access chained onto the second error cycle (R12)
    run_write("R7", 1'b1, 2'b10, 1, 32'h3000, 3'd2, 32'h55555555, 4'hF, 1'b1);
    run_read("R12", 1'b0, 2'b00, 0, 32'h3004, 32'h0BADCAFE, 1'b0);
    run_read("R7", 1'b0, 2'b11, 0, 32'h3008, 32'h0, 1'b0);
    run_read("R7", 1'b1, 2'b10, 3, 32'h300C, 32'h0, 1'b1);
    // reads (R1, R4), chained onto completions (R12)
    run_read("R4", 1'b1, 2'b01, 0, 32'h4000, 32'hA5A5A5A5, 1'b0);
    run_read("R4", 1'b1, 2'b00, 4, 32'h4004, 32'h5A5A5A5A, 1'b1);
    run_read("R5", 1'b0, 2'b00, 2, 32'h4008, 32'h01234567, 1'b0);
    run_write("R12", 1'b0, 2'b00, 0, 32'h400C, 3'd2, 32'h76543210, 4'hF, 1'b0);
    t_clear();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule